// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block keeps the one reservation that a processor core holds for atomic read-modify-write sequences. A decoded load-reserve request opens the reservation and records the word it touched. A later store-conditional request is granted its memory write only while a reservation is open. The store-conditional does not compare its address with the recorded word. Every store-conditional closes the reservation, whether it is granted or refused. Reset, interrupt entry, exception entry and break entry close the reservation as well.

For each store-conditional the block drives, in the same cycle, a write enable toward the memory port. It also drives a carry-style status flag: 0 means the store was performed and 1 means it was refused. An unpaired store-conditional to any address can therefore be used simply to drop a held reservation. A debug output shows whether a reservation is open and which word it covers.

The control is a two-state machine. EMPTY means no reservation and HELD means a reservation is open. There are four named transitions:
- RESERVE (EMPTY to HELD) on a load-reserve.
- RELOAD (HELD to HELD) on a further load-reserve, which replaces the recorded word.
- CONSUME (HELD to EMPTY) on a store-conditional.
- CANCEL (HELD or EMPTY to EMPTY) on a clear event.

Top module: `resv_unit`

## Requirements
- R1: While and directly after reset, `dbg_valid` is 0, `dbg_word` is 0, and `sc_wr_en` and `sc_carry` are 0.
- R2: A load-reserve with no clear event in the same cycle leaves `dbg_valid` at 1 after the next clock edge. In that case `dbg_word` equals bits [ADDR_W-1:2] of `req_addr`.
- R3: A load-reserve while a reservation is already held replaces `dbg_word` with the new word and keeps `dbg_valid` at 1.
- R4: A store-conditional while `dbg_valid` is 1 gives `sc_wr_en`=1 and `sc_carry`=0 in the same cycle, whatever its address.
- R5: A store-conditional while `dbg_valid` is 0 gives `sc_wr_en`=0 and `sc_carry`=1 in the same cycle.
- R6: After any store-conditional, `dbg_valid` is 0 following the clock edge.
- R7: If any of `clr_irq`, `clr_exc` or `clr_brk` is 1 in a cycle, `dbg_valid` is 0 after that clock edge.
- R8: A clear event in the same cycle as a load-reserve takes priority, so the reservation ends up invalid.
- R9: Bits [1:0] of `req_addr` are ignored. Addresses that differ only in those bits reserve the same word, and no fault is raised.
- R10: In a cycle without a store-conditional, `sc_wr_en` and `sc_carry` are both 0.
- R11: Without a load-reserve, `dbg_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the reservation |
| lr_req | input | 1 | Decoded load-reserve request |
| sc_req | input | 1 | Decoded store-conditional request |
| req_addr | input | ADDR_W | Byte address of the request |
| clr_irq | input | 1 | Interrupt entry, clears the reservation |
| clr_exc | input | 1 | Exception entry, clears the reservation |
| clr_brk | input | 1 | Break entry (hardware or software), clears the reservation |
| sc_wr_en | output | 1 | Memory write enable for the store-conditional |
| sc_carry | output | 1 | Status flag: 1 = store refused, 0 = store performed |
| dbg_valid | output | 1 | Reservation currently held |
| dbg_word | output | ADDR_W-2 | Recorded word address |

## Verification
The assertions assume that decode never raises `lr_req` and `sc_req` in the same cycle, because one instruction cannot be both. They check this assumption as well. Clear events may coincide with either request and are not restricted. The sweep holds the two requests mutually exclusive. For each request type it applies every combination of the three clear inputs, starting from both an empty and a held reservation. It uses addresses whose low two bits vary.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_HELD  = 1'b1
    } resv_state_t;

endpackage

// File: rtl/resv_fsm.sv
module resv_fsm
    import resv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lr_go,
    input  logic        sc_go,
    input  logic        cancel,
    output resv_state_t state,
    output logic        reserve_ld
);

    resv_state_t state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_EMPTY;
        else        state <= state_nxt;
    end

    // transitions: RESERVE, RELOAD, CONSUME, CANCEL
    always_comb begin
        state_nxt  = state;
        reserve_ld = 1'b0;
        unique case (state)
            RS_EMPTY: begin
                if (cancel) begin
                    state_nxt = RS_EMPTY;           // CANCEL
                end else if (lr_go && !sc_go) begin
                    state_nxt  = RS_HELD;           // RESERVE
                    reserve_ld = 1'b1;
                end
            end
            RS_HELD: begin
                if (cancel || sc_go) begin
                    state_nxt = RS_EMPTY;           // CANCEL / CONSUME
                end else if (lr_go) begin
                    state_nxt  = RS_HELD;           // RELOAD
                    reserve_ld = 1'b1;
                end
            end
            default: state_nxt = RS_EMPTY;
        endcase
    end

endmodule

// File: rtl/resv_word_reg.sv
module resv_word_reg #(
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/resv_sc_decide.sv
module resv_sc_decide
    import resv_pkg::*;
(
    input  logic        sc_go,
    input  resv_state_t state,
    output logic        wr_en,
    output logic        carry
);

    always_comb begin
        wr_en = 1'b0;
        carry = 1'b0;
        if (sc_go) begin
            unique case (state)
                RS_HELD:  wr_en = 1'b1;
                RS_EMPTY: carry = 1'b1;
                default:  carry = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/resv_unit.sv
module resv_unit
    import resv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_req,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              clr_irq,
    input  logic              clr_exc,
    input  logic              clr_brk,
    output logic              sc_wr_en,
    output logic              sc_carry,
    output logic              dbg_valid,
    output logic [ADDR_W-3:0] dbg_word
);

    localparam int WORD_W = ADDR_W - 2;

    resv_state_t       state;
    logic              cancel;
    logic              reserve_ld;
    logic [WORD_W-1:0] req_word;
    logic              addr_lo_unused;

    assign cancel         = clr_irq | clr_exc | clr_brk;
    assign req_word       = req_addr[ADDR_W-1:2];
    assign addr_lo_unused = ^req_addr[1:0];

    resv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_go      (lr_req),
        .sc_go      (sc_req),
        .cancel     (cancel),
        .state      (state),
        .reserve_ld (reserve_ld)
    );

    resv_word_reg #(.WORD_W(WORD_W)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reserve_ld),
        .d     (req_word),
        .q     (dbg_word)
    );

    resv_sc_decide u_dec (
        .sc_go (sc_req),
        .state (state),
        .wr_en (sc_wr_en),
        .carry (sc_carry)
    );

    assign dbg_valid = (state == RS_HELD);

endmodule

// File: rtl/resv_chk.sv
module resv_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lr_req,
    input logic              sc_req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              clr_irq,
    input logic              clr_exc,
    input logic              clr_brk,
    input logic              sc_wr_en,
    input logic              sc_carry,
    input logic              dbg_valid,
    input logic [ADDR_W-3:0] dbg_word
);

    logic any_clr;
    assign any_clr = clr_irq | clr_exc | clr_brk;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(lr_req && sc_req));
    AST_LR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_req && !sc_req && !any_clr) |=> (dbg_valid && dbg_word == $past(req_addr[ADDR_W-1:2]))); // R2
    AST_SC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && dbg_valid) |-> (sc_wr_en && !sc_carry)); // R4
    AST_SC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !dbg_valid) |-> (!sc_wr_en && sc_carry)); // R5
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> !dbg_valid); // R6
    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        any_clr |=> !dbg_valid); // R7
    AST_CLR_BEATS_LR: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && lr_req) |=> !dbg_valid); // R8
    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |-> (!sc_wr_en && !sc_carry)); // R10
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lr_req |=> $stable(dbg_word)); // R11

endmodule

bind resv_unit resv_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lr_req    (lr_req),
    .sc_req    (sc_req),
    .req_addr  (req_addr),
    .clr_irq   (clr_irq),
    .clr_exc   (clr_exc),
    .clr_brk   (clr_brk),
    .sc_wr_en  (sc_wr_en),
    .sc_carry  (sc_carry),
    .dbg_valid (dbg_valid),
    .dbg_word  (dbg_word)
);

// File: tb/sim_resv_unit.sv
module sim_resv_unit;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lr_req = 1'b0;
    logic              sc_req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              clr_irq = 1'b0;
    logic              clr_exc = 1'b0;
    logic              clr_brk = 1'b0;
    logic              sc_wr_en;
    logic              sc_carry;
    logic              dbg_valid;
    logic [ADDR_W-3:0] dbg_word;

    int vectors = 0;
    int errors  = 0;

    // bench model
    logic              m_valid = 1'b0;
    logic [ADDR_W-3:0] m_word  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req),
        .req_addr(req_addr), .clr_irq(clr_irq), .clr_exc(clr_exc),
        .clr_brk(clr_brk), .sc_wr_en(sc_wr_en), .sc_carry(sc_carry),
        .dbg_valid(dbg_valid), .dbg_word(dbg_word)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one request cycle: op 0=none 1=load-reserve 2=store-conditional
    task automatic step(input int op, input logic [2:0] clr, input logic [ADDR_W-1:0] addr);
        logic e_wr, e_cy, n_valid;
        logic [ADDR_W-3:0] n_word;
        string tag_out, tag_st;
        @(negedge clk);
        lr_req   = (op == 1);
        sc_req   = (op == 2);
        req_addr = addr;
        {clr_irq, clr_exc, clr_brk} = clr;
        #1;
        e_wr = (op == 2) && m_valid;
        e_cy = (op == 2) && !m_valid;
        tag_out = (op != 2) ? "R10" : (m_valid ? "R4" : "R5");
        check({tag_out, " wr_en"}, sc_wr_en, e_wr);
        check({tag_out, " carry"}, sc_carry, e_cy);
        n_valid = m_valid;
        n_word  = m_word;
        if (clr != 3'b000) n_valid = 1'b0;
        else if (op == 2) n_valid = 1'b0;
        else if (op == 1) begin n_valid = 1'b1; n_word = addr >> 2; end
        if (clr != 3'b000) tag_st = (op == 1) ? "R8" : "R7";
        else if (op == 2)  tag_st = "R6";
        else if (op == 1)  tag_st = m_valid ? "R3 R9" : "R2 R9";
        else               tag_st = "R11";
        @(posedge clk);
        #1;
        m_valid = n_valid;
        m_word  = n_word;
        check({tag_st, " valid"}, dbg_valid, m_valid);
        if (m_valid || clr == 3'b000) check({tag_st, " word"}, dbg_word, m_word);
        lr_req = 1'b0;
        sc_req = 1'b0;
        {clr_irq, clr_exc, clr_brk} = 3'b000;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] addrs [4];
        addrs[0] = 32'h0000_1000;
        addrs[1] = 32'h0000_1003;
        addrs[2] = 32'hFFFF_FFFC;
        addrs[3] = 32'h1234_5679;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", dbg_valid, 1'b0);
        check("R1 word in reset", dbg_word, '0);
        check("R1 wr_en in reset", sc_wr_en, 1'b0);
        check("R1 carry in reset", sc_carry, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 valid after reset", dbg_valid, 1'b0);

        // R9: low bits ignored, same word for 0x1000 and 0x1003
        step(1, 3'b000, 32'h0000_1003);
        check("R9 word of 0x1003", dbg_word, 30'h400);
        step(2, 3'b000, 32'h0000_2000);   // consumes, R4 on different address

        for (int s = 0; s < 2; s++)
            for (int op = 0; op < 3; op++)
                for (int c = 0; c < 8; c++)
                    for (int a = 0; a < 4; a++) begin
                        if (s == 1) step(1, 3'b000, addrs[(a + 1) % 4] ^ 32'h40);
                        else        step(2, 3'b000, addrs[a]);
                        step(op, c[2:0], addrs[a]);
                    end

        // unpaired store-conditional discards, then a second one fails
        step(1, 3'b000, 32'h0000_0010);
        step(2, 3'b000, 32'hDEAD_BEE0);
        step(2, 3'b000, 32'h0000_0010);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule